// File: doc/BRIEF.md
# Cube Pair Distance and Exorlink Generator

This unit compares two product terms (cubes) over a fixed number of variables. Each cube is held in two-bit positional form, one field per variable. When a start pulse is accepted, the unit captures both cubes. One cycle later it presents two counts. The distance is how many variables carry opposite literals. The difference is how many variables carry non-identical fields. It also raises a flag that says whether the pair can be merged under exclusive-sum rules.

In the same cycle that the counts appear, the unit begins to stream the exorlink cube set, one cube per clock. It produces one result cube for each differing variable, taken in ascending position. Each result cube is spliced from the two inputs: the first cube's fields below the position, the XOR of the two fields at the position, and the second cube's fields above it. A search engine that minimises exclusive-sum-of-products covers uses this unit as its inner step, consuming the streamed cubes as candidate replacements.

Top module: `cube_link_engine`

## Requirements
- R1: Variable i occupies bits [2i+1:2i] of a cube port. Code 10 is the true literal, 01 the complemented literal and 11 an absent variable.
- R2: One cycle after an accepted start, `distance` shows the number of positions where the bitwise AND of the two codes is 00.
- R3: One cycle after an accepted start, `difference` shows the number of positions whose codes differ, and `busy` is high exactly when that count is nonzero.
- R4: `mergeable` is high exactly when `difference` is 0 or 1.
- R5: `difference` is never smaller than `distance`.
- R6: After an accepted start, `resValid` is high for exactly `difference` consecutive cycles, starting in the cycle the counts appear. It is never high while `busy` is low.
- R7: The k-th result cube (k from 0) belongs to the k-th differing position p, counted upward from position 0. Below p it carries the first cube's fields, at p the XOR of both fields, and above p the second cube's fields.
- R8: At the linking position, 10 against 11 gives 01, 01 against 11 gives 10, and 10 against 01 gives 11.
- R9: `resLast` is high on the final result cube only, and `busy` is low in the cycle after it.
- R10: A start while `busy` is high is ignored: the counts, the flag and the remaining cubes are unchanged.
- R11: `resErr` is high when the emitted linking field is 00. It stays low for any pair of valid codes.
- R12: After reset, `busy`, `resValid` and both counts are 0, and `mergeable` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Capture the cubes and begin a comparison |
| cubeA | input | 2*NumVars | First cube |
| cubeB | input | 2*NumVars | Second cube |
| busy | output | 1 | Result cubes are being emitted |
| distance | output | clog2(NumVars+1) | Count of opposing literals |
| difference | output | clog2(NumVars+1) | Count of non-identical fields |
| mergeable | output | 1 | Difference is at most one |
| resValid | output | 1 | resCube holds a result cube |
| resLast | output | 1 | Final result cube of the set |
| resCube | output | 2*NumVars | Current exorlink result cube |
| resErr | output | 1 | Linking field came out empty |

## Verification
The hardest case to reach from the ports is a start pulse that arrives while a stream is in flight. It must change neither the counts nor the cubes still to come. The stimulus therefore fires a second start with unrelated cubes on the first stream cycle of many random pairs. It then checks every later cube against the original pair. Directed pairs cover the extreme positions: all fields opposed, identical cubes, and a single absent-against-present field at the lowest and highest variable. The same pairs also exercise every XOR polarity.

// File: rtl/cube_link_pkg.sv
package cube_link_pkg;
  typedef struct packed {
    logic load;
    logic advance;
  } linkStrobe_t;
endpackage

// File: rtl/cube_link_ctrl.sv
module cube_link_ctrl #(
  parameter int NumVars = 8
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              start,
  input  logic [NumVars-1:0]                diffMaskLive,
  output cube_link_pkg::linkStrobe_t        strobe,
  output logic [NumVars-1:0]                curSel,
  output logic                              busy,
  output logic                              resValid,
  output logic                              resLast
);
  localparam logic [NumVars-1:0] One = NumVars'(1);

  logic [NumVars-1:0] pending;
  logic [NumVars-1:0] rest;

  assign busy     = |pending;
  assign curSel   = pending & (~pending + One);
  assign rest     = pending & ~curSel;
  assign resValid = busy;
  assign resLast  = busy && (rest == '0);

  always_comb begin
    strobe.load    = start && !busy;
    strobe.advance = busy;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pending <= '0;
    else if (strobe.load) pending <= diffMaskLive;
    else if (strobe.advance) pending <= rest;
  end
endmodule

// File: rtl/cube_link_dp.sv
module cube_link_dp #(
  parameter int NumVars = 8,
  parameter int CntW    = $clog2(NumVars + 1)
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  cube_link_pkg::linkStrobe_t    strobe,
  input  logic [2*NumVars-1:0]          cubeA,
  input  logic [2*NumVars-1:0]          cubeB,
  input  logic [NumVars-1:0]            curSel,
  output logic [NumVars-1:0]            diffMaskLive,
  output logic [CntW-1:0]               distance,
  output logic [CntW-1:0]               difference,
  output logic                          mergeable,
  output logic [2*NumVars-1:0]          resCube,
  output logic                          resErr
);
  localparam logic [NumVars-1:0] One = NumVars'(1);

  logic [2*NumVars-1:0] regA, regB;
  logic [CntW-1:0]      distLive, diffLive;
  logic [NumVars-1:0]   lowerMask;
  logic [1:0]           selXor;

  always_comb begin
    distLive = '0;
    diffLive = '0;
    for (int i = 0; i < NumVars; i++) begin
      diffMaskLive[i] = cubeA[2*i +: 2] != cubeB[2*i +: 2];
      diffLive = diffLive + CntW'(diffMaskLive[i]);
      distLive = distLive + CntW'((cubeA[2*i +: 2] & cubeB[2*i +: 2]) == 2'b00);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regA       <= '0;
      regB       <= '0;
      distance   <= '0;
      difference <= '0;
    end else if (strobe.load) begin
      regA       <= cubeA;
      regB       <= cubeB;
      distance   <= distLive;
      difference <= diffLive;
    end
  end

  assign mergeable = difference <= CntW'(1);
  assign lowerMask = curSel - One;

  for (genvar g = 0; g < NumVars; g++) begin : g_field
    assign resCube[2*g +: 2] = curSel[g]    ? (regA[2*g +: 2] ^ regB[2*g +: 2]) :
                               lowerMask[g] ? regA[2*g +: 2] : regB[2*g +: 2];
  end

  always_comb begin
    selXor = 2'b00;
    for (int i = 0; i < NumVars; i++)
      if (curSel[i]) selXor = regA[2*i +: 2] ^ regB[2*i +: 2];
  end

  assign resErr = (|curSel) && (selXor == 2'b00);
endmodule

// File: rtl/cube_link_engine.sv
module cube_link_engine #(
  parameter int NumVars = 8,
  parameter int CntW    = $clog2(NumVars + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  input  logic [2*NumVars-1:0] cubeA,
  input  logic [2*NumVars-1:0] cubeB,
  output logic                 busy,
  output logic [CntW-1:0]      distance,
  output logic [CntW-1:0]      difference,
  output logic                 mergeable,
  output logic                 resValid,
  output logic                 resLast,
  output logic [2*NumVars-1:0] resCube,
  output logic                 resErr
);
  cube_link_pkg::linkStrobe_t strobe;
  logic [NumVars-1:0] diffMaskLive;
  logic [NumVars-1:0] curSel;

  cube_link_ctrl #(.NumVars(NumVars)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .diffMaskLive(diffMaskLive),
    .strobe(strobe), .curSel(curSel), .busy(busy),
    .resValid(resValid), .resLast(resLast)
  );

  cube_link_dp #(.NumVars(NumVars), .CntW(CntW)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cubeA(cubeA), .cubeB(cubeB),
    .curSel(curSel), .diffMaskLive(diffMaskLive), .distance(distance),
    .difference(difference), .mergeable(mergeable), .resCube(resCube),
    .resErr(resErr)
  );
endmodule

// File: rtl/cube_link_chk.sv
module cube_link_chk #(
  parameter int NumVars = 8,
  parameter int CntW    = $clog2(NumVars + 1)
) (
  input logic            clk,
  input logic            rstN,
  input logic            start,
  input logic            busy,
  input logic [CntW-1:0] distance,
  input logic [CntW-1:0] difference,
  input logic            resValid,
  input logic            resLast
);
  a_r5_diff_covers_dist: assert property (@(posedge clk) disable iff (!rstN)
    difference >= distance);

  a_r6_valid_needs_busy: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> busy);

  a_r9_idle_after_last: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && resLast) |=> !busy);

  a_r10_counts_hold: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> ($stable(distance) && $stable(difference)));

  a_r3_busy_tracks_diff: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> (busy == (difference != '0)));
endmodule

bind cube_link_engine cube_link_chk #(.NumVars(NumVars), .CntW(CntW)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy), .distance(distance),
  .difference(difference), .resValid(resValid), .resLast(resLast)
);

// File: tb/cube_link_engine_tb.sv
module cube_link_engine_tb;
  localparam int NV = 8;
  localparam int CW = 2 * NV;
  localparam int KW = $clog2(NV + 1);

  logic clk = 0, rstN = 0, start = 0;
  logic [CW-1:0] cubeA = '0, cubeB = '0;
  logic busy, mergeable, resValid, resLast, resErr;
  logic [KW-1:0] distance, difference;
  logic [CW-1:0] resCube;
  int nCmp = 0, nBad = 0;

  always #2 clk = ~clk;

  cube_link_engine #(.NumVars(NV)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .cubeA(cubeA), .cubeB(cubeB),
    .busy(busy), .distance(distance), .difference(difference),
    .mergeable(mergeable), .resValid(resValid), .resLast(resLast),
    .resCube(resCube), .resErr(resErr)
  );

  function automatic int expDist(logic [CW-1:0] a, logic [CW-1:0] b);
    int n = 0;
    for (int i = 0; i < NV; i++) if ((a[2*i +: 2] & b[2*i +: 2]) == 2'b00) n++;
    return n;
  endfunction

  function automatic int expDiff(logic [CW-1:0] a, logic [CW-1:0] b);
    int n = 0;
    for (int i = 0; i < NV; i++) if (a[2*i +: 2] != b[2*i +: 2]) n++;
    return n;
  endfunction

  function automatic logic [CW-1:0] expCube(logic [CW-1:0] a, logic [CW-1:0] b, int k);
    logic [CW-1:0] r;
    int p = 0, seen = 0;
    for (int i = NV - 1; i >= 0; i--) ;
    for (int i = 0; i < NV; i++)
      if (a[2*i +: 2] != b[2*i +: 2]) begin
        if (seen == k) p = i;
        seen++;
      end
    for (int j = 0; j < NV; j++)
      r[2*j +: 2] = (j < p) ? a[2*j +: 2] : (j == p) ? (a[2*j +: 2] ^ b[2*j +: 2]) : b[2*j +: 2];
    return r;
  endfunction

  function automatic logic [CW-1:0] randCube();
    logic [CW-1:0] c;
    for (int i = 0; i < NV; i++) begin
      int r = $urandom % 3;
      c[2*i +: 2] = (r == 0) ? 2'b10 : (r == 1) ? 2'b01 : 2'b11;
    end
    return c;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nCmp++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic runPair(input logic [CW-1:0] a, input logic [CW-1:0] b, input bit inject);
    int d, f;
    logic [CW-1:0] ec;
    @(negedge clk);
    cubeA = a; cubeB = b; start = 1;
    @(negedge clk);
    start = 0;
    d = expDist(a, b);
    f = expDiff(a, b);
    check(distance == KW'(d), "R2 distance", 32'(distance), 32'(d));
    check(difference == KW'(f), "R3 difference", 32'(difference), 32'(f));
    check(busy == (f != 0), "R3 busy", 32'(busy), 32'(f != 0));
    check(mergeable == (f <= 1), "R4 mergeable", 32'(mergeable), 32'(f <= 1));
    for (int k = 0; k < f; k++) begin
      ec = expCube(a, b, k);
      check(resValid == 1'b1, "R6 resValid", 32'(resValid), 32'd1);
      check(resCube == ec, "R7 resCube", 32'(resCube), 32'(ec));
      check(resLast == (k == f - 1), "R9 resLast", 32'(resLast), 32'(k == f - 1));
      check(resErr == 1'b0, "R11 resErr", 32'(resErr), 32'd0);
      if (inject && k > 0) begin
        check(distance == KW'(d) && difference == KW'(f), "R10 counts held",
              32'({distance, difference}), 32'({KW'(d), KW'(f)}));
      end
      if (inject && k == 0) begin
        cubeA = randCube(); cubeB = ~randCube(); start = 1;
      end
      @(negedge clk);
      start = 0;
    end
    check(busy == 1'b0, "R9 busy drops", 32'(busy), 32'd0);
    check(resValid == 1'b0, "R6 resValid off", 32'(resValid), 32'd0);
  endtask

  function automatic logic [CW-1:0] fill(logic [1:0] code);
    logic [CW-1:0] c;
    for (int i = 0; i < NV; i++) c[2*i +: 2] = code;
    return c;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    logic [CW-1:0] a, b;
    void'($urandom(32'd20240607));
    repeat (3) @(negedge clk);
    check(busy == 0 && resValid == 0, "R12 reset control", 32'({busy, resValid}), 32'd0);
    check(distance == 0 && difference == 0, "R12 reset counts", 32'({distance, difference}), 32'd0);
    check(mergeable == 1, "R12 reset mergeable", 32'(mergeable), 32'd1);
    rstN = 1;
    // R1 R2 R3: all positions opposed
    runPair(fill(2'b10), fill(2'b01), 1'b0);
    // R3 R4: identical cubes produce no stream
    runPair(fill(2'b11), fill(2'b11), 1'b0);
    // R8 R1: lowest position true vs absent links to complemented literal
    a = fill(2'b11); a[1:0] = 2'b10;
    runPair(a, fill(2'b11), 1'b0);
    @(negedge clk);
    // R8: highest position complemented vs absent yields true literal
    a = fill(2'b11); a[CW-1 -: 2] = 2'b01;
    cubeA = a; cubeB = fill(2'b11); start = 1;
    @(negedge clk);
    start = 0;
    check(resCube[CW-1 -: 2] == 2'b10, "R8 polarity high", 32'(resCube[CW-1 -: 2]), 32'h2);
    check(resLast == 1'b1, "R9 single last", 32'(resLast), 32'd1);
    @(negedge clk);
    // R10: start during stream from directed pair
    runPair(fill(2'b10), fill(2'b11), 1'b1);
    for (int t = 0; t < 300; t++) begin
      a = randCube();
      b = randCube();
      if (t % 5 == 0) b = a;
      runPair(a, b, (t % 3) == 0);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule